// File: doc/BRIEF.md
# Block-Aligned DMA Transfer Splitter

This block takes one DMA transfer, given as a byte start address, a byte count and a direction, and turns it into a sequence of memory requests. Each request stays inside one aligned memory block of `BLK_BYTES` bytes. A transfer that starts in the middle of a block gets a short head chunk, which carries its in-block offset. Every chunk after the head begins on a block boundary. Only one chunk is in flight at any time. The next chunk goes out only after the previous one has completed: a read chunk completes when its block data returns, and a write chunk completes when it is acknowledged.

For writes, each request carries the matching slice of the transfer's write data. For reads, the returned block bytes are packed into a byte buffer at the transfer's running position. The block holds one transfer at a time. It answers an accepted start in the same cycle with a fresh transfer ID, and later raises a single completion pulse that carries that ID.

Top module: `dma_block_splitter`

## Requirements
- R1: A start (`start_valid`) is accepted only when the block is idle, `start_kind` is 1 (read) or 2 (write), and `start_len` is between 1 and `BUF_BYTES`. On acceptance `start_ok` is high in that same cycle. Any other start raises `start_err` in that cycle, and the block's state does not change.
- R2: `busy` rises on the clock edge that accepts a transfer. It stays high until the completion pulse.
- R3: The first chunk has `req_addr` equal to the start address and `req_offset` equal to the start address modulo `BLK_BYTES`. Its `req_len` is min(len, `BLK_BYTES` − offset), so a transfer that fits inside one block is sent as a single chunk of exactly len bytes.
- R4: Every later chunk has `req_addr` equal to the start address plus the bytes completed so far. That address is block aligned, `req_offset` is 0, and `req_len` is min(remaining bytes, `BLK_BYTES`).
- R5: A chunk counts as issued only on a `req_valid`/`req_ready` handshake. While `req_ready` is low the request fields stay unchanged. After a handshake, `req_valid` stays low until that chunk's response has arrived.
- R6: A read chunk completes only on `rsp_data_valid`, and a write chunk completes only on `rsp_ack`. A response of the other kind, or any response while no chunk is outstanding, has no effect.
- R7: For a write chunk, byte i of `req_wdata` (bits 8i+7:8i) is byte (completed + i) of `start_wdata` for i < `req_len`. All other bytes of `req_wdata` are zero.
- R8: For a read chunk, buffer byte (completed + i) of `rd_buf` receives byte (`req_offset` + i) of `rsp_data` for i < the chunk length. No other buffer byte changes.
- R9: One cycle after the response that completes the last chunk, `done` is high for exactly one cycle with `done_id` equal to the transfer's ID. In that cycle `busy` is low and no further request is made.
- R10: `start_id` gives the ID of the transfer being accepted. IDs increase by one (modulo 2^`ID_W`) with each accepted transfer, and a rejected start uses no ID.
- R11: After reset `busy`, `req_valid` and `done` are low, `rd_buf` is all zero, and the first accepted transfer receives ID 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_valid | input | 1 | Start a transfer this cycle |
| start_kind | input | 3 | Transfer type: 1 read, 2 write, other codes illegal |
| start_addr | input | ADDR_W | Byte start address |
| start_len | input | LEN_W | Byte count |
| start_wdata | input | BUF_BYTES*8 | Write bytes, byte j at bits 8j+7:8j |
| start_ok | output | 1 | Start accepted this cycle |
| start_err | output | 1 | Start rejected this cycle |
| start_id | output | ID_W | ID given to the accepted transfer |
| busy | output | 1 | A transfer is active |
| req_valid | output | 1 | Chunk request valid |
| req_ready | input | 1 | Memory side takes the request |
| req_addr | output | ADDR_W | Chunk byte address |
| req_offset | output | OFS_W | In-block offset of the chunk |
| req_len | output | CL_W | Chunk byte count |
| req_write | output | 1 | Chunk is a write |
| req_wdata | output | BLK_BYTES*8 | Write bytes, starting at byte lane 0 |
| rsp_data_valid | input | 1 | Read block data returned |
| rsp_data | input | BLK_BYTES*8 | Returned block bytes |
| rsp_ack | input | 1 | Write acknowledged |
| rd_buf | output | BUF_BYTES*8 | Packed read bytes |
| done | output | 1 | Transfer complete pulse |
| done_id | output | ID_W | ID of the completed transfer |

## Verification
The completion pulse of one transfer and the acceptance of the next one can fall in the same cycle, because the block is already idle while `done` is high. To provoke this, the bench keeps a read start asserted across the final write acknowledgement. It then expects the start to be refused in the acknowledgement cycle, and in the following cycle expects `done` with the old ID alongside `start_ok` with the next ID. The bench also drives a start while a chunk is waiting on the request port, and responses of the wrong kind between handshakes. In both cases it checks that nothing moves.

// File: rtl/dma_split_pkg.sv
package dma_split_pkg;

  typedef enum logic [2:0] {
    KIND_NONE  = 3'd0,
    KIND_READ  = 3'd1,
    KIND_WRITE = 3'd2,
    KIND_FETCH = 3'd3,
    KIND_LKRD  = 3'd4,
    KIND_LKWR  = 3'd5
  } xfer_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } split_st_e;

endpackage

// File: rtl/dma_chunk_calc.sv
module dma_chunk_calc #(
  parameter int ADDR_W    = 32,
  parameter int BLK_BYTES = 16,
  parameter int LEN_W     = 7,
  localparam int OFS_W    = $clog2(BLK_BYTES),
  localparam int CL_W     = $clog2(BLK_BYTES + 1)
) (
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [LEN_W-1:0]  total_len,
  input  logic [LEN_W-1:0]  done_bytes,
  output logic [ADDR_W-1:0] ch_addr,
  output logic [OFS_W-1:0]  ch_ofs,
  output logic [CL_W-1:0]   ch_len
);

  localparam int CW = ((LEN_W > CL_W) ? LEN_W : CL_W) + 1;

  logic          first;
  logic [CW-1:0] room;
  logic [CW-1:0] remain;
  logic [CW-1:0] pick;

  always_comb begin
    first   = (done_bytes == '0);
    ch_ofs  = first ? base_addr[OFS_W-1:0] : '0;
    ch_addr = base_addr + ADDR_W'(done_bytes);
    room    = CW'(BLK_BYTES) - CW'(ch_ofs);
    remain  = CW'(total_len) - CW'(done_bytes);
    pick    = (remain < room) ? remain : room;
    ch_len  = pick[CL_W-1:0];
  end

endmodule

// File: rtl/dma_read_pack.sv
module dma_read_pack #(
  parameter int BLK_BYTES = 16,
  parameter int BUF_BYTES = 64,
  parameter int LEN_W     = 7,
  localparam int OFS_W    = $clog2(BLK_BYTES),
  localparam int BLK_W    = BLK_BYTES * 8,
  localparam int BUF_W    = BUF_BYTES * 8
) (
  input  logic [BLK_W-1:0] blk_data,
  input  logic [OFS_W-1:0] src_ofs,
  input  logic [LEN_W-1:0] dst_pos,
  input  logic [LEN_W-1:0] cnt,
  output logic [BUF_W-1:0] put_data,
  output logic [BUF_W-1:0] put_mask
);

  logic [BLK_W-1:0] aligned;
  logic [LEN_W:0]   lim;

  always_comb begin
    aligned  = blk_data >> {src_ofs, 3'b000};
    put_data = BUF_W'(aligned) << {dst_pos, 3'b000};
    lim      = {1'b0, dst_pos} + {1'b0, cnt};
  end

  for (genvar j = 0; j < BUF_BYTES; j++) begin : g_mask
    assign put_mask[8*j +: 8] =
      ((LEN_W+1)'(j) >= {1'b0, dst_pos} && (LEN_W+1)'(j) < lim) ? 8'hFF : 8'h00;
  end

endmodule

// File: rtl/dma_block_splitter.sv
module dma_block_splitter
  import dma_split_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BLK_BYTES = 16,
  parameter int BUF_BYTES = 64,
  parameter int ID_W      = 4,
  localparam int OFS_W    = $clog2(BLK_BYTES),
  localparam int CL_W     = $clog2(BLK_BYTES + 1),
  localparam int LEN_W    = $clog2(BUF_BYTES + 1),
  localparam int BLK_W    = BLK_BYTES * 8,
  localparam int BUF_W    = BUF_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_valid,
  input  logic [2:0]        start_kind,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  start_len,
  input  logic [BUF_W-1:0]  start_wdata,
  output logic              start_ok,
  output logic              start_err,
  output logic [ID_W-1:0]   start_id,
  output logic              busy,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic [OFS_W-1:0]  req_offset,
  output logic [CL_W-1:0]   req_len,
  output logic              req_write,
  output logic [BLK_W-1:0]  req_wdata,
  input  logic              rsp_data_valid,
  input  logic [BLK_W-1:0]  rsp_data,
  input  logic              rsp_ack,
  output logic [BUF_W-1:0]  rd_buf,
  output logic              done,
  output logic [ID_W-1:0]   done_id
);

  split_st_e         st_q, st_d;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  len_q;
  logic              wr_q;
  logic [ID_W-1:0]   id_q, id_ctr_q, id_ctr_d;
  logic [LEN_W-1:0]  iss_q, iss_d, cmp_q, cmp_d;
  logic [BUF_W-1:0]  wbuf_q, rbuf_q, rbuf_d;
  logic              done_q, done_d;
  logic [ID_W-1:0]   done_id_q;

  logic              kind_ok, len_ok, rsp_hit, last_chunk;
  logic [ADDR_W-1:0] ch_addr;
  logic [OFS_W-1:0]  ch_ofs;
  logic [CL_W-1:0]   ch_len;
  logic [BUF_W-1:0]  wshift, put_data, put_mask;
  logic [LEN_W-1:0]  rd_cnt;

  // start-side decode
  always_comb begin
    kind_ok   = (start_kind == KIND_READ) || (start_kind == KIND_WRITE);
    len_ok    = (start_len != '0) && (start_len <= LEN_W'(BUF_BYTES));
    start_ok  = start_valid && (st_q == ST_IDLE) && kind_ok && len_ok;
    start_err = start_valid && !start_ok;
    start_id  = id_ctr_q;
  end

  dma_chunk_calc #(
    .ADDR_W    (ADDR_W),
    .BLK_BYTES (BLK_BYTES),
    .LEN_W     (LEN_W)
  ) u_chunk (
    .base_addr  (addr_q),
    .total_len  (len_q),
    .done_bytes (cmp_q),
    .ch_addr    (ch_addr),
    .ch_ofs     (ch_ofs),
    .ch_len     (ch_len)
  );

  // write slice: bytes from the completed position, lane 0 upward
  assign wshift = wbuf_q >> {cmp_q, 3'b000};
  for (genvar b = 0; b < BLK_BYTES; b++) begin : g_wlane
    assign req_wdata[8*b +: 8] = (CL_W'(b) < ch_len) ? wshift[8*b +: 8] : 8'h00;
  end

  assign rd_cnt = iss_q - cmp_q;

  dma_read_pack #(
    .BLK_BYTES (BLK_BYTES),
    .BUF_BYTES (BUF_BYTES),
    .LEN_W     (LEN_W)
  ) u_pack (
    .blk_data (rsp_data),
    .src_ofs  (ch_ofs),
    .dst_pos  (cmp_q),
    .cnt      (rd_cnt),
    .put_data (put_data),
    .put_mask (put_mask)
  );

  always_comb begin
    req_valid  = (st_q == ST_ISSUE);
    req_addr   = ch_addr;
    req_offset = ch_ofs;
    req_len    = ch_len;
    req_write  = wr_q;
    busy       = (st_q != ST_IDLE);
    rd_buf     = rbuf_q;
    done       = done_q;
    done_id    = done_id_q;
    rsp_hit    = (st_q == ST_WAIT) && (wr_q ? rsp_ack : rsp_data_valid);
    last_chunk = (iss_q == len_q);
  end

  // next state
  always_comb begin
    st_d     = st_q;
    iss_d    = iss_q;
    cmp_d    = cmp_q;
    done_d   = 1'b0;
    id_ctr_d = id_ctr_q;
    rbuf_d   = rbuf_q;
    unique case (st_q)
      ST_IDLE: begin
        if (start_ok) begin
          st_d     = ST_ISSUE;
          iss_d    = '0;
          cmp_d    = '0;
          id_ctr_d = id_ctr_q + 1'b1;
        end
      end
      ST_ISSUE: begin
        if (req_ready) begin
          iss_d = iss_q + LEN_W'(ch_len);
          st_d  = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (rsp_hit) begin
          cmp_d = iss_q;
          if (!wr_q) rbuf_d = (rbuf_q & ~put_mask) | (put_data & put_mask);
          if (last_chunk) begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
          end else begin
            st_d = ST_ISSUE;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      iss_q     <= '0;
      cmp_q     <= '0;
      done_q    <= 1'b0;
      done_id_q <= '0;
      id_ctr_q  <= '0;
      rbuf_q    <= '0;
    end else begin
      st_q     <= st_d;
      iss_q    <= iss_d;
      cmp_q    <= cmp_d;
      done_q   <= done_d;
      id_ctr_q <= id_ctr_d;
      rbuf_q   <= rbuf_d;
      if (done_d) done_id_q <= id_q;
    end
  end

  // transfer descriptor, loaded on acceptance only
  always_ff @(posedge clk) begin
    if (start_ok) begin
      addr_q <= start_addr;
      len_q  <= start_len;
      wr_q   <= (start_kind == KIND_WRITE);
      wbuf_q <= start_wdata;
      id_q   <= id_ctr_q;
    end
  end

  // R1: no acceptance while a transfer is active
  p_busy_refuse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start_ok);

  // R2: acceptance makes the block busy on the next cycle
  p_busy_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> busy);

  // R3: a chunk never runs past its block and is never empty
  p_fit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_len != '0) && (int'(req_offset) + int'(req_len) <= BLK_BYTES));

  // R4: later chunks start on a block boundary
  p_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && cmp_q != '0) |-> (req_offset == '0) && (req_addr[OFS_W-1:0] == '0));

  // R5: request held while not taken
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> req_valid && $stable(req_addr) &&
                                  $stable(req_len) && $stable(req_offset));

  // R5: one chunk in flight: handshake drops the request
  p_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_valid);

  // R5: completed bytes never pass issued bytes
  p_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_q <= iss_q);

  // R9: completion is a single pulse while idle
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !req_valid);

endmodule

// File: tb/dma_block_splitter_tb.sv
module dma_block_splitter_tb_top;

  localparam int ADDR_W    = 32;
  localparam int BLK_BYTES = 16;
  localparam int BUF_BYTES = 64;
  localparam int ID_W      = 4;
  localparam int OFS_W     = $clog2(BLK_BYTES);
  localparam int CL_W      = $clog2(BLK_BYTES + 1);
  localparam int LEN_W     = $clog2(BUF_BYTES + 1);
  localparam int BLK_W     = BLK_BYTES * 8;
  localparam int BUF_W     = BUF_BYTES * 8;

  // vector: {kind[44:42], addr[41:10], len[9:3], lag[2:1], inject[0]}
  localparam int NV = 8;
  localparam logic [44:0] VEC [NV] = '{
    {3'd1, 32'h0000_0100, 7'd16, 2'd0, 1'b0},
    {3'd1, 32'h0000_0105, 7'd5,  2'd1, 1'b0},
    {3'd1, 32'h0000_010A, 7'd30, 2'd0, 1'b1},
    {3'd2, 32'h0000_0203, 7'd40, 2'd2, 1'b1},
    {3'd2, 32'h0000_0200, 7'd64, 2'd0, 1'b0},
    {3'd1, 32'h0000_033F, 7'd2,  2'd0, 1'b1},
    {3'd2, 32'h0000_040E, 7'd2,  2'd1, 1'b0},
    {3'd1, 32'h0000_0501, 7'd64, 2'd1, 1'b0}
  };

  logic              clk = 1'b0;
  logic              rst_n;
  logic              start_valid;
  logic [2:0]        start_kind;
  logic [ADDR_W-1:0] start_addr;
  logic [LEN_W-1:0]  start_len;
  logic [BUF_W-1:0]  start_wdata;
  logic              start_ok, start_err;
  logic [ID_W-1:0]   start_id;
  logic              busy, req_valid, req_ready, req_write;
  logic [ADDR_W-1:0] req_addr;
  logic [OFS_W-1:0]  req_offset;
  logic [CL_W-1:0]   req_len;
  logic [BLK_W-1:0]  req_wdata;
  logic              rsp_data_valid, rsp_ack;
  logic [BLK_W-1:0]  rsp_data;
  logic [BUF_W-1:0]  rd_buf;
  logic              done;
  logic [ID_W-1:0]   done_id;

  always #10 clk = ~clk;  // 50 MHz

  dma_block_splitter #(
    .ADDR_W(ADDR_W), .BLK_BYTES(BLK_BYTES), .BUF_BYTES(BUF_BYTES), .ID_W(ID_W)
  ) dut_i (
    .clk(clk), .rst_n(rst_n),
    .start_valid(start_valid), .start_kind(start_kind), .start_addr(start_addr),
    .start_len(start_len), .start_wdata(start_wdata),
    .start_ok(start_ok), .start_err(start_err), .start_id(start_id), .busy(busy),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_offset(req_offset), .req_len(req_len), .req_write(req_write),
    .req_wdata(req_wdata), .rsp_data_valid(rsp_data_valid), .rsp_data(rsp_data),
    .rsp_ack(rsp_ack), .rd_buf(rd_buf), .done(done), .done_id(done_id)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [ID_W-1:0]  nid;
  logic [BUF_W-1:0] exp_rbuf;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [7:0] mem_byte(input logic [31:0] a);
    logic [31:0] t;
    t = a * 32'd37 + 32'd11;
    return t[7:0] ^ a[15:8];
  endfunction

  function automatic logic [7:0] wpat(input int seed, input int j);
    logic [31:0] t;
    t = 32'(j * 3 + seed);
    return t[7:0];
  endfunction

  function automatic logic [BLK_W-1:0] mem_block(input logic [31:0] a);
    logic [BLK_W-1:0] v;
    logic [31:0] base;
    base = a & ~32'(BLK_BYTES - 1);
    for (int k = 0; k < BLK_BYTES; k++) v[8*k +: 8] = mem_byte(base + 32'(k));
    return v;
  endfunction

  task automatic check_rbuf(input string tag);
    int mis;
    mis = 0;
    for (int j = 0; j < BUF_BYTES; j++)
      if (rd_buf[8*j +: 8] !== exp_rbuf[8*j +: 8]) mis++;
    chk(mis == 0, tag, 64'(mis), 64'd0);
  endtask

  // Called at a negedge (+1) where the next chunk request is expected.
  task automatic serve(input logic [31:0] addr, input int len, input bit wr,
                       input int seed, input int lag, input bit inj,
                       input logic [ID_W-1:0] id);
    int dn, ofs, room, clen;
    logic [BLK_W-1:0] ew;
    dn = 0;
    while (dn < len) begin
      ofs  = (dn == 0) ? int'(addr % BLK_BYTES) : 0;
      room = BLK_BYTES - ofs;
      clen = ((len - dn) < room) ? (len - dn) : room;
      for (int w = 0; w < lag; w++) begin
        chk(req_valid === 1'b1, "R5 request held while not ready", 64'(req_valid), 64'd1);
        @(negedge clk); #1;
      end
      req_ready = 1'b1;
      #1;
      chk(req_valid === 1'b1, "R5 request valid", 64'(req_valid), 64'd1);
      chk(req_addr === addr + 32'(dn), (dn == 0) ? "R3 first address" : "R4 later address",
          64'(req_addr), 64'(addr + 32'(dn)));
      chk(req_offset === OFS_W'(ofs), (dn == 0) ? "R3 first offset" : "R4 later offset zero",
          64'(req_offset), 64'(ofs));
      chk(req_len === CL_W'(clen), (dn == 0) ? "R3 first length" : "R4 later length",
          64'(req_len), 64'(clen));
      chk(req_write === wr, "R7 request type", 64'(req_write), 64'(wr));
      if (wr) begin
        for (int b = 0; b < BLK_BYTES; b++) ew[8*b +: 8] = (b < clen) ? wpat(seed, dn + b) : 8'h00;
        chk(req_wdata === ew, "R7 write slice", 64'(req_wdata), 64'(ew));
      end
      @(negedge clk);
      req_ready = 1'b0;
      #1;
      chk(req_valid === 1'b0, "R5 nothing issued before response", 64'(req_valid), 64'd0);
      if (inj) begin
        rsp_ack        = !wr;
        rsp_data_valid = wr;
        rsp_data       = '1;
        @(negedge clk);
        rsp_ack = 1'b0; rsp_data_valid = 1'b0;
        #1;
        chk(req_valid === 1'b0 && busy === 1'b1 && done === 1'b0,
            "R6 wrong response ignored", 64'(req_valid), 64'd0);
        check_rbuf("R6 buffer untouched by wrong response");
      end
      rsp_ack        = wr;
      rsp_data_valid = !wr;
      rsp_data       = mem_block(addr + 32'(dn));
      if (!wr)
        for (int i = 0; i < clen; i++) exp_rbuf[8*(dn+i) +: 8] = mem_byte(addr + 32'(dn + i));
      dn += clen;
      @(negedge clk);
      rsp_ack = 1'b0; rsp_data_valid = 1'b0;
      #1;
    end
    chk(done === 1'b1 && done_id === id, "R9 done with ID", 64'({done, done_id}), 64'({1'b1, id}));
    chk(busy === 1'b0 && req_valid === 1'b0, "R9 idle at completion", 64'({busy, req_valid}), 64'd0);
    check_rbuf("R8 packed read bytes");
    @(negedge clk); #1;
    chk(done === 1'b0, "R9 done is one pulse", 64'(done), 64'd0);
  endtask

  task automatic drive_start(input logic [2:0] k, input logic [31:0] a, input int len,
                             input int seed);
    start_valid = 1'b1;
    start_kind  = k;
    start_addr  = a;
    start_len   = LEN_W'(len);
    for (int j = 0; j < BUF_BYTES; j++) start_wdata[8*j +: 8] = wpat(seed, j);
  endtask

  task automatic run_xfer(input logic [44:0] v, input int seed);
    logic [ID_W-1:0] id;
    @(negedge clk);
    drive_start(v[44:42], v[41:10], int'(v[9:3]), seed);
    #1;
    chk(start_ok === 1'b1 && start_err === 1'b0, "R1 legal start accepted",
        64'({start_ok, start_err}), 64'b10);
    chk(start_id === nid, "R10 start ID", 64'(start_id), 64'(nid));
    id  = nid;
    nid = nid + 1'b1;
    @(negedge clk);
    start_valid = 1'b0;
    #1;
    chk(busy === 1'b1, "R2 busy after acceptance", 64'(busy), 64'd1);
    serve(v[41:10], int'(v[9:3]), v[44:42] == 3'd2, seed, int'(v[2:1]), v[0], id);
  endtask

  task automatic reject(input logic [2:0] k, input int len, input string tag);
    @(negedge clk);
    drive_start(k, 32'h60, len, 1);
    #1;
    chk(start_err === 1'b1 && start_ok === 1'b0, tag, 64'({start_ok, start_err}), 64'b01);
    @(negedge clk);
    start_valid = 1'b0;
    #1;
    chk(busy === 1'b0 && req_valid === 1'b0, "R1 rejected start leaves block idle",
        64'({busy, req_valid}), 64'd0);
  endtask

  initial begin
    #(20 * 150000);
    chk(1'b0, "watchdog expired", 64'd0, 64'd1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [ID_W-1:0] id0;
    rst_n = 1'b0; start_valid = 1'b0; start_kind = '0; start_addr = '0;
    start_len = '0; start_wdata = '0; req_ready = 1'b0;
    rsp_data_valid = 1'b0; rsp_ack = 1'b0; rsp_data = '0;
    nid = '0; exp_rbuf = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(busy === 1'b0 && req_valid === 1'b0 && done === 1'b0, "R11 reset outputs low",
        64'({busy, req_valid, done}), 64'd0);
    chk(rd_buf === '0, "R11 buffer cleared", 64'(rd_buf), 64'd0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(start_id === '0, "R11 first ID is zero", 64'(start_id), 64'd0);

    // illegal starts consume no ID
    reject(3'd0, 4, "R1 null kind rejected");
    reject(3'd3, 4, "R1 fetch kind rejected");
    reject(3'd4, 4, "R1 locked read rejected");
    reject(3'd5, 4, "R1 locked write rejected");
    reject(3'd1, 0, "R1 zero length rejected");
    reject(3'd2, BUF_BYTES + 1, "R1 oversize length rejected");

    for (int v = 0; v < NV; v++) run_xfer(VEC[v], 7 * v + 1);

    // busy refusal, then completion and next acceptance in one cycle
    @(negedge clk);
    drive_start(3'd2, 32'h80, 4, 9);
    #1;
    chk(start_ok === 1'b1 && start_id === nid, "R10 write start ID", 64'(start_id), 64'(nid));
    id0 = nid;
    nid = nid + 1'b1;
    @(negedge clk);
    drive_start(3'd1, 32'h130, 3, 0);
    req_ready = 1'b1;
    #1;
    chk(start_err === 1'b1 && start_ok === 1'b0, "R1 start refused while issuing",
        64'({start_ok, start_err}), 64'b01);
    chk(req_len === CL_W'(4) && req_offset === '0, "R3 single chunk of len", 64'(req_len), 64'd4);
    @(negedge clk);
    req_ready = 1'b0;
    rsp_ack   = 1'b1;
    #1;
    chk(start_ok === 1'b0, "R1 start refused in response cycle", 64'(start_ok), 64'd0);
    @(negedge clk);
    rsp_ack = 1'b0;
    #1;
    chk(done === 1'b1 && done_id === id0, "R9 done beside new start",
        64'(done_id), 64'(id0));
    chk(start_ok === 1'b1 && start_id === nid, "R10 next ID in done cycle",
        64'(start_id), 64'(nid));
    @(negedge clk);
    start_valid = 1'b0;
    #1;
    chk(busy === 1'b1 && done === 1'b0, "R2 busy after back-to-back accept",
        64'({busy, done}), 64'b10);
    serve(32'h130, 3, 1'b0, 0, 0, 1'b0, nid);
    nid = nid + 1'b1;

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule